// File: doc/BRIEF.md
# Radix-256 Sequential Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles and returns a 32-bit quotient and a 32-bit remainder. It is meant to sit beside an execute stage. The stage raises `start` for one cycle with the operands and a signed/unsigned select. The block answers with `busy` in that same cycle, and the pipeline stays stalled while `busy` is high. When `busy` drops, the result registers hold the answer.

In the start cycle the operands are reduced to magnitudes and the sign information is latched. Every compute cycle then chains eight restoring subtract-and-shift steps in combinational logic, which gives eight quotient bits per clock. Each step subtracts by adding the inverted divisor plus one in a widened adder and reads the carry-out. After the last compute cycle the quotient and remainder get their signs corrected and are registered in the same clock. A two-state controller drives `busy` as a Mealy output.

Top module: `seqdiv_radix256`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy` is 0 and `quotient` and `remainder` are 0. This holds even when reset arrives in the middle of an operation.
- R2: When the block is idle and `start` is 1, `busy` is 1 in that same cycle, without waiting for a clock edge.
- R3: `busy` stays high for exactly WIDTH/STEPS+1 consecutive cycles (5 with the defaults), counting the start cycle. It is low in the next cycle, and the result is valid from that cycle on.
- R4: With `signed_mode`=0, the operands are treated as unsigned. `quotient` is floor(dividend/divisor) and `remainder` is dividend minus quotient times divisor.
- R5: With `signed_mode`=1, the operands are two's complement. The quotient is truncated toward zero, so it is negated when exactly one operand is negative. -2^31 divided by -1 gives 0x80000000.
- R6: With `signed_mode`=1, a nonzero remainder has the sign of the dividend, and dividend = quotient*divisor + remainder.
- R7: A divisor of 0 gives `quotient` = 0xFFFFFFFF and `remainder` = the dividend, in either mode, with the same `busy` length as R3.
- R8: `start`, the operands and `signed_mode` are ignored from the cycle after the start cycle up to and including the cycle in which `busy` falls. Such a `start` neither changes the result nor raises `busy` in the following cycle.
- R9: While the block stays idle, `quotient` and `remainder` hold their values whatever the inputs do, as long as `start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; taken only when idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled in the start cycle |
| divisor | input | WIDTH | Divisor, sampled in the start cycle |
| busy | output | 1 | Stall request, high from the start cycle until completion |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered remainder |

## Verification
Two functions can share a cycle: the completion cycle, where the controller releases `busy` and returns to idle, and a fresh `start` that a stalled pipeline could present in that same cycle. The bench holds `start` high with new operands through the falling edge of `busy`. It then checks that `busy` stays low in the next cycle and that the registered result still belongs to the first operation. A second directed case raises `start` with a different mode and operands in the middle of a running division. It checks that the latched sign handling and operands of the first request survive.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dstate_e;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import seqdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic busy,
  output logic load,
  output logic step,
  output logic running
);
  dstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    busy    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          busy    = 1'b1;
        end
      end
      ST_RUN: begin
        if (done) begin
          state_d = ST_IDLE;
          busy    = 1'b0;
        end else begin
          busy    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign load    = (state_q == ST_IDLE) && start;
  assign step    = (state_q == ST_RUN) && !done;
  assign running = (state_q == ST_RUN);

  // R2: an accepted request moves the controller into the compute state
  p_enter_run_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start) |=> (state_q == ST_RUN));

  // R8: a request seen while computing cannot keep the controller in the compute state
  p_done_leaves_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && done) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int WIDTH = 32
) (
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] a_mag,
  output logic [WIDTH-1:0] b_mag,
  output logic             a_neg,
  output logic             b_neg
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assign a_neg = signed_mode & dividend[WIDTH-1];
  assign b_neg = signed_mode & divisor[WIDTH-1];
  assign a_mag = a_neg ? (~dividend + ONE) : dividend;
  assign b_mag = b_neg ? (~divisor + ONE) : divisor;
endmodule

// File: rtl/sdiv_slice.sv
module sdiv_slice #(
  parameter int WIDTH = 32,
  parameter int STEPS = 8
) (
  input  logic [2*WIDTH-1:0] r_in,
  input  logic [2*WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0]   q_in,
  output logic [2*WIDTH-1:0] r_out,
  output logic [2*WIDTH-1:0] d_out,
  output logic [WIDTH-1:0]   q_out
);
  localparam int RW = 2 * WIDTH;
  localparam logic [RW:0] ONE_X = {{RW{1'b0}}, 1'b1};

  logic [RW-1:0]    rr [STEPS+1];
  logic [RW-1:0]    dd [STEPS+1];
  logic [WIDTH-1:0] qq [STEPS+1];

  assign rr[0] = r_in;
  assign dd[0] = d_in;
  assign qq[0] = q_in;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic [RW:0] diff;
    logic        fits;
    assign diff      = {1'b0, rr[i]} + {1'b0, ~dd[i]} + ONE_X;
    assign fits      = diff[RW];
    assign rr[i+1]   = fits ? diff[RW-1:0] : rr[i];
    assign qq[i+1]   = {qq[i][WIDTH-2:0], fits};
    assign dd[i+1]   = {1'b0, dd[i][RW-1:1]};
  end

  assign r_out = rr[STEPS];
  assign d_out = dd[STEPS];
  assign q_out = qq[STEPS];

  // R7: a zero divisor always fits, so the remainder is untouched and every new bit is 1
  always_comb begin
    if (d_in == '0) begin
      p_zero_div_r7: assert (r_out == r_in && q_out[STEPS-1:0] == {STEPS{1'b1}});
    end
  end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
  parameter int WIDTH = 32
) (
  input  logic             q_neg,
  input  logic             r_neg,
  input  logic [WIDTH-1:0] q_mag,
  input  logic [WIDTH-1:0] r_mag,
  output logic [WIDTH-1:0] q_fixed,
  output logic [WIDTH-1:0] r_fixed
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assign q_fixed = q_neg ? (~q_mag + ONE) : q_mag;
  assign r_fixed = r_neg ? (~r_mag + ONE) : r_mag;
endmodule

// File: rtl/seqdiv_radix256.sv
module seqdiv_radix256 #(
  parameter int WIDTH = 32,
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int RW   = 2 * WIDTH;
  localparam int NCYC = WIDTH / STEPS;
  localparam int CW   = $clog2(NCYC + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(NCYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(NCYC - 1);

  logic [WIDTH-1:0] a_mag, b_mag;
  logic             a_neg, b_neg;
  logic [RW-1:0]    rem_q, dvs_q, rem_nx, dvs_nx;
  logic [WIDTH-1:0] quo_q, quo_nx;
  logic [CW-1:0]    cnt_q;
  logic             qneg_q, rneg_q;
  logic [RW-1:0]    res_q;
  logic [WIDTH-1:0] q_fixed, r_fixed;
  logic             done, load, step, running;

  sdiv_prep #(.WIDTH(WIDTH)) u_prep (
    .signed_mode(signed_mode),
    .dividend   (dividend),
    .divisor    (divisor),
    .a_mag      (a_mag),
    .b_mag      (b_mag),
    .a_neg      (a_neg),
    .b_neg      (b_neg)
  );

  sdiv_slice #(.WIDTH(WIDTH), .STEPS(STEPS)) u_slice (
    .r_in (rem_q),
    .d_in (dvs_q),
    .q_in (quo_q),
    .r_out(rem_nx),
    .d_out(dvs_nx),
    .q_out(quo_nx)
  );

  sdiv_fix #(.WIDTH(WIDTH)) u_fix (
    .q_neg  (qneg_q),
    .r_neg  (rneg_q),
    .q_mag  (quo_nx),
    .r_mag  (rem_nx[WIDTH-1:0]),
    .q_fixed(q_fixed),
    .r_fixed(r_fixed)
  );

  assign done = (cnt_q == CNT_DONE);

  sdiv_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .load   (load),
    .step   (step),
    .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      res_q  <= '0;
    end else if (load) begin
      rem_q  <= {{WIDTH{1'b0}}, a_mag};
      dvs_q  <= {{WIDTH{1'b0}}, b_mag} << (WIDTH - 1);
      quo_q  <= '0;
      cnt_q  <= '0;
      qneg_q <= (a_neg ^ b_neg) && (divisor != '0);
      rneg_q <= a_neg;
    end else if (step) begin
      rem_q <= rem_nx;
      dvs_q <= dvs_nx;
      quo_q <= quo_nx;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        res_q <= {r_fixed, q_fixed};
      end
    end
  end

  assign quotient  = res_q[WIDTH-1:0];
  assign remainder = res_q[RW-1:WIDTH];

  // checker state: length of the current run of busy-high cycles
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R3: busy stays high through the start cycle and every compute cycle
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run_len != '0 && run_len <= (CW+1)'(NCYC)) |-> busy);

  // R3: busy is low once the start cycle and all compute cycles have passed
  p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
    (run_len == (CW+1)'(NCYC + 1)) |-> !busy);

  // R8: the latched sign handling cannot change while an operation runs
  p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(qneg_q) && $stable(rneg_q)));

  // R9: outputs stay put across consecutive idle cycles
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(res_q));
endmodule

// File: tb/test_seqdiv_radix256.sv
module test_seqdiv_radix256;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        signed_mode;
  logic [31:0] dividend, divisor;
  logic        busy;
  logic [31:0] quotient, remainder;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  seqdiv_radix256 i_seqdiv_radix256 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .signed_mode(signed_mode),
    .dividend   (dividend),
    .divisor    (divisor),
    .busy       (busy),
    .quotient   (quotient),
    .remainder  (remainder)
  );

  // stimulus vectors: {signed_mode, dividend, divisor}
  localparam int NV = 16;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFFFFFF,   32'd1},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {1'b0, 32'd5,          32'd9},
    {1'b0, 32'hDEADBEEF,   32'h00012345},
    {1'b0, 32'h80000000,   32'hFFFFFFFF},
    {1'b1, 32'hFFFFFF9C,   32'd7},
    {1'b1, 32'd100,        32'hFFFFFFF9},
    {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9},
    {1'b1, 32'h80000000,   32'hFFFFFFFF},
    {1'b1, 32'h7FFFFFFF,   32'h80000000},
    {1'b1, 32'hFFFFFFFD,   32'd5},
    {1'b0, 32'd1234,       32'd0},
    {1'b1, 32'hFFFFFB2E,   32'd0},
    {1'b0, 32'h80000000,   32'd0},
    {1'b1, 32'd42,         32'd42}
  };

  function automatic void expect_of(input logic m, input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] q, output logic [31:0] r);
    longint sa, sb, lq, lr;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (b == 32'd0) begin
      q = 32'hFFFFFFFF;
      r = a;
    end else if (m) begin
      lq = sa / sb;
      lr = sa % sb;
      q  = lq[31:0];
      r  = lr[31:0];
    end else begin
      q = a / b;
      r = a % b;
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // issue one request at a falling edge and count the busy-high cycles
  task automatic run_op(input logic m, input logic [31:0] a, input logic [31:0] b, output int cyc);
    @(negedge clk);
    signed_mode = m;
    dividend    = a;
    divisor     = b;
    start       = 1'b1;
    #1;
    chk("R2 busy in start cycle", {31'd0, busy}, 32'd1);
    cyc = 1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] eq, er, hq, hr;
    rst = 1'b1; start = 1'b0; signed_mode = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 quotient in reset", quotient, 32'd0);
    chk("R1 remainder in reset", remainder, 32'd0);
    rst = 1'b0;

    // table walk: R4 unsigned, R5/R6 signed, R7 zero divisor, R3 latency
    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k][64], VEC[k][63:32], VEC[k][31:0], cyc);
      expect_of(VEC[k][64], VEC[k][63:32], VEC[k][31:0], eq, er);
      chk("R3 busy length", cyc, 32'd5);
      if (VEC[k][31:0] == 32'd0) begin
        chk("R7 quotient", quotient, eq);
        chk("R7 remainder", remainder, er);
      end else if (VEC[k][64]) begin
        chk("R5 quotient", quotient, eq);
        chk("R6 remainder", remainder, er);
      end else begin
        chk("R4 quotient", quotient, eq);
        chk("R4 remainder", remainder, er);
      end
    end

    // R9: idle outputs unaffected by input changes without start
    hq = quotient; hr = remainder;
    @(negedge clk);
    signed_mode = 1'b1; dividend = 32'h12345678; divisor = 32'd3;
    repeat (3) @(negedge clk);
    chk("R9 quotient held", quotient, hq);
    chk("R9 remainder held", remainder, hr);

    // R8: new request and mode change in the middle of an operation are ignored
    @(negedge clk);
    signed_mode = 1'b0; dividend = 32'd1000; divisor = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    signed_mode = 1'b1; dividend = 32'hFFFFFFCE; divisor = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
    chk("R8 busy length with mid-run start", cyc, 32'd5);
    chk("R8 quotient of first request", quotient, 32'd333);
    chk("R8 remainder of first request", remainder, 32'd1);

    // R8: start held high up to and through the cycle busy falls is not accepted
    @(negedge clk);
    signed_mode = 1'b0; dividend = 32'd77; divisor = 32'd10; start = 1'b1;
    cyc = 0;
    #1;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
      #1;
    end
    chk("R3 busy length with held start", cyc, 32'd5);
    dividend = 32'd9; divisor = 32'd2;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R8 no restart after completion cycle", {31'd0, busy}, 32'd0);
    chk("R8 quotient kept", quotient, 32'd7);
    chk("R8 remainder kept", remainder, 32'd7);

    // R1: reset in the middle of an operation
    @(negedge clk);
    signed_mode = 1'b0; dividend = 32'd500; divisor = 32'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 busy after mid-run reset", {31'd0, busy}, 32'd0);
    chk("R1 quotient after mid-run reset", quotient, 32'd0);
    chk("R1 remainder after mid-run reset", remainder, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset release", {31'd0, busy}, 32'd0);

    // operation after reset works normally
    run_op(1'b1, 32'hFFFFFFF1, 32'd4, cyc);
    chk("R3 busy length after reset", cyc, 32'd5);
    chk("R5 quotient after reset", quotient, 32'hFFFFFFFD);
    chk("R6 remainder after reset", remainder, 32'hFFFFFFFD);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule